// File: doc/BRIEF.md
# Program Counter Latch Unit

This block holds the fetch address for a processor whose program space is addressed in bytes and stored as 16-bit words. The address is split into three bytes: a low byte that software can read and write directly, and a high byte and an upper byte that software reaches only through two holding latches. Software loads the latches first and then writes the low byte, so the whole address changes in one step.

On every step where nothing else happens and the increment enable is high, the address moves forward by one word, which is two bytes. A computed jump adds an 8-bit byte offset to the low byte and loads the high and upper bytes from the latches. This is how a lookup table made of return-literal words is indexed. A read of the low byte copies the live high and upper bytes into the latches, so that a later jump stays in the current region. Bit 0 of the address is always zero, so a fetch from an odd address cannot occur.

Top module: `pcl_unit`

## Requirements
- R1: After a synchronous active-high reset, the fetch address, the high latch and the upper latch are all zero.
- R2: With `inc_en` high and no write or jump to the low byte, the fetch address grows by 2 on the next edge. The carry ripples into the high and upper bytes, and the address wraps to zero above the largest value that `ADDR_W` bits can hold.
- R3: Bit 0 of `fetch_addr` is zero at all times. An odd value written or summed into the low byte lands on the even address just below it.
- R4: `reg_rdata` shows the selected register in the same cycle. A read (`reg_rd` high, `reg_wr` low) at select 0 returns the live low byte, and at that edge it copies the live high byte and upper bits into their latches.
- R5: A write at select 0 sets the next address to {upper latch, high latch, `reg_wdata` with bit 0 cleared}. This write takes precedence over `inc_en`.
- R6: With `add_en` high, the next low byte is the 8-bit sum of the current low byte and `add_val` with bit 0 cleared. No carry passes out of the low byte, the upper bits are loaded from the latches, and the latches are not refreshed. `add_en` takes precedence over register writes to the low byte and over `inc_en`.
- R7: The high latch (select 1) and the upper latch (select 2) are read/write registers. They keep their value while the address steps or jumps. The upper latch stores only `ADDR_W-16` bits and reads back with zeros above them.
- R8: Select 3 reads as zero. A write to select 3 changes neither latch nor the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inc_en | input | 1 | Advance the address by one word |
| add_en | input | 1 | Computed jump: add `add_val` to the low byte |
| add_val | input | 8 | Byte offset for the computed jump |
| reg_addr | input | 2 | Register select: 0 low byte, 1 high latch, 2 upper latch, 3 none |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (ignored while `reg_wr` is high) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the selected register |
| fetch_addr | output | ADDR_W | Current byte fetch address |

## Verification
The hardest state to reach is a latch that holds a value different from the live address bytes at the moment a computed jump fires. This is the case that shows the jump pulls its upper bits from the latches and not from the address. The stimulus builds it by stepping the address across a 256-byte boundary after the latches were loaded, so the jump lands back in the earlier region. It then reads the latches back to show the jump did not refresh them. The lookup-table pattern is checked separately: a low-byte read refreshes stale latches before the offset is added.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 2;

    typedef enum logic [1:0] {
        SEL_LOW   = 2'd0,
        SEL_HIGH  = 2'd1,
        SEL_UPPER = 2'd2,
        SEL_NONE  = 2'd3
    } pcl_sel_e;

    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_STEP = 2'd1,
        UPD_LOAD = 2'd2
    } pcl_upd_e;

    typedef struct packed {
        pcl_upd_e upd;
        logic     use_add;
        logic     hi_wr;
        logic     up_wr;
        logic     refresh;
    } pcl_ctrl_t;

    function automatic logic [BYTE_W-1:0] pcl_align(input logic [BYTE_W-1:0] b);
        return {b[BYTE_W-1:1], 1'b0};
    endfunction

endpackage

// File: rtl/pcl_decode.sv
module pcl_decode
    import pcl_pkg::*;
(
    input  logic       inc_en,
    input  logic       add_en,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    output pcl_ctrl_t  ctrl
);

    pcl_sel_e sel;
    logic     rd_eff;

    always_comb begin
        sel    = pcl_sel_e'(reg_addr);
        rd_eff = reg_rd & ~reg_wr;

        ctrl         = '0;
        ctrl.upd     = UPD_HOLD;
        ctrl.hi_wr   = reg_wr && (sel == SEL_HIGH);
        ctrl.up_wr   = reg_wr && (sel == SEL_UPPER);
        ctrl.refresh = rd_eff && (sel == SEL_LOW);

        if (add_en) begin
            ctrl.upd     = UPD_LOAD;
            ctrl.use_add = 1'b1;
        end else if (reg_wr && (sel == SEL_LOW)) begin
            ctrl.upd     = UPD_LOAD;
            ctrl.use_add = 1'b0;
        end else if (inc_en) begin
            ctrl.upd     = UPD_STEP;
        end
    end

endmodule

// File: rtl/pcl_latch_bank.sv
module pcl_latch_bank
    import pcl_pkg::*;
#(
    parameter int UP_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  pcl_ctrl_t         ctrl,
    input  logic [BYTE_W-1:0] hi_wdata,
    input  logic [UP_W-1:0]   up_wdata,
    input  logic [BYTE_W-1:0] pc_hi,
    input  logic [UP_W-1:0]   pc_up,
    output logic [BYTE_W-1:0] hi_q,
    output logic [UP_W-1:0]   up_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            up_q <= '0;
        end else begin
            if (ctrl.hi_wr) begin
                hi_q <= hi_wdata;
            end else if (ctrl.refresh) begin
                hi_q <= pc_hi;
            end
            if (ctrl.up_wr) begin
                up_q <= up_wdata;
            end else if (ctrl.refresh) begin
                up_q <= pc_up;
            end
        end
    end

endmodule

// File: rtl/pcl_counter.sv
module pcl_counter
    import pcl_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic                 clk,
    input  logic                 rst,
    input  pcl_ctrl_t            ctrl,
    input  logic [BYTE_W-1:0]    wdata,
    input  logic [BYTE_W-1:0]    add_val,
    input  logic [BYTE_W-1:0]    hi_q,
    input  logic [ADDR_W-17:0]   up_q,
    output logic [ADDR_W-1:0]    pc_q
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [BYTE_W-1:0] jump_src;
    logic [ADDR_W-1:0] pc_d;

    always_comb begin
        jump_src = ctrl.use_add ? (pc_q[BYTE_W-1:0] + add_val) : wdata;
        case (ctrl.upd)
            UPD_STEP: pc_d = pc_q + STEP;
            UPD_LOAD: pc_d = {up_q, hi_q, pcl_align(jump_src)};
            default:  pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

endmodule

// File: rtl/pcl_read_mux.sv
module pcl_read_mux
    import pcl_pkg::*;
#(
    parameter int UP_W = 5
) (
    input  logic [1:0]        reg_addr,
    input  logic [BYTE_W-1:0] pc_low,
    input  logic [BYTE_W-1:0] hi_q,
    input  logic [UP_W-1:0]   up_q,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] up_ext;

    generate
        if (UP_W < BYTE_W) begin : g_pad
            assign up_ext = {{(BYTE_W-UP_W){1'b0}}, up_q};
        end else begin : g_full
            assign up_ext = up_q[BYTE_W-1:0];
        end
    endgenerate

    always_comb begin
        case (pcl_sel_e'(reg_addr))
            SEL_LOW:   rdata = pc_low;
            SEL_HIGH:  rdata = hi_q;
            SEL_UPPER: rdata = up_ext;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/pcl_unit.sv
module pcl_unit
    import pcl_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_en,
    input  logic              add_en,
    input  logic [7:0]        add_val,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [ADDR_W-1:0] fetch_addr
);

    localparam int UP_W = ADDR_W - 2 * BYTE_W;

    pcl_ctrl_t         ctrl;
    logic [BYTE_W-1:0] hi_latch;
    logic [UP_W-1:0]   up_latch;
    logic [ADDR_W-1:0] pc_q;

    pcl_decode u_decode (
        .inc_en   (inc_en),
        .add_en   (add_en),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .ctrl     (ctrl)
    );

    pcl_latch_bank #(.UP_W(UP_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .hi_wdata (reg_wdata),
        .up_wdata (reg_wdata[UP_W-1:0]),
        .pc_hi    (pc_q[2*BYTE_W-1:BYTE_W]),
        .pc_up    (pc_q[ADDR_W-1:2*BYTE_W]),
        .hi_q     (hi_latch),
        .up_q     (up_latch)
    );

    pcl_counter #(.ADDR_W(ADDR_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .wdata   (reg_wdata),
        .add_val (add_val),
        .hi_q    (hi_latch),
        .up_q    (up_latch),
        .pc_q    (pc_q)
    );

    pcl_read_mux #(.UP_W(UP_W)) u_rmux (
        .reg_addr (reg_addr),
        .pc_low   (pc_q[BYTE_W-1:0]),
        .hi_q     (hi_latch),
        .up_q     (up_latch),
        .rdata    (reg_rdata)
    );

    assign fetch_addr = pc_q;

endmodule

// File: rtl/pcl_unit_chk.sv
module pcl_unit_chk #(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst,
    input logic              inc_en,
    input logic              add_en,
    input logic [7:0]        add_val,
    input logic [1:0]        reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [7:0]        reg_wdata,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [7:0]        hi_latch,
    input logic [ADDR_W-17:0] up_latch
);

    logic [ADDR_W-1:0] step_c;
    logic [7:0]        sum_c;
    logic              low_wr_c;

    assign step_c   = fetch_addr + ADDR_W'(2);
    assign sum_c    = fetch_addr[7:0] + add_val;
    assign low_wr_c = reg_wr && (reg_addr == 2'd0);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fetch_addr == '0 && hi_latch == '0 && up_latch == '0)); // R1

    AST_STEP_TWO: assert property (@(posedge clk) disable iff (rst)
        (inc_en && !add_en && !low_wr_c) |=> fetch_addr == $past(step_c)); // R2

    AST_EVEN_FETCH: assert property (@(posedge clk) disable iff (rst)
        fetch_addr[0] == 1'b0); // R3

    AST_READ_REFRESH: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && reg_addr == 2'd0) |=>
        (hi_latch == $past(fetch_addr[15:8]) && up_latch == $past(fetch_addr[ADDR_W-1:16]))); // R4

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (low_wr_c && !add_en) |=>
        fetch_addr == {$past(up_latch), $past(hi_latch), $past(reg_wdata[7:1]), 1'b0}); // R5

    AST_ADD_LOW: assert property (@(posedge clk) disable iff (rst)
        add_en |=> fetch_addr[7:0] == {$past(sum_c[7:1]), 1'b0}); // R6

    AST_ADD_KEEP_LATCH: assert property (@(posedge clk) disable iff (rst)
        (add_en && !reg_wr) |=> ($stable(hi_latch) && $stable(up_latch))); // R6

    AST_NONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd3 && !add_en && !inc_en) |=>
        ($stable(hi_latch) && $stable(up_latch) && $stable(fetch_addr))); // R8

endmodule

bind pcl_unit pcl_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .inc_en     (inc_en),
    .add_en     (add_en),
    .add_val    (add_val),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .fetch_addr (fetch_addr),
    .hi_latch   (hi_latch),
    .up_latch   (up_latch)
);

// File: tb/pcl_unit_tb.sv
`timescale 1ns/1ps
module pcl_unit_tb;

    localparam int AW = 21;
    localparam int UW = AW - 16;

    typedef struct {
        logic [AW-1:0] exp_pc;
        logic [7:0]    exp_rd;
        bit            chk_rd;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          inc_en = 1'b0, add_en = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]    add_val = '0, reg_wdata = '0;
    logic [1:0]    reg_addr = '0;
    logic [7:0]    reg_rdata;
    logic [AW-1:0] fetch_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    item_t q[$];

    logic [AW-1:0] m_pc = '0;
    logic [7:0]    m_hi = '0;
    logic [UW-1:0] m_up = '0;

    always #2.5 clk = ~clk;

    pcl_unit #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .inc_en(inc_en), .add_en(add_en), .add_val(add_val),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fetch_addr(fetch_addr)
    );

    // Monitor: pops the item queued for this cycle and compares.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (fetch_addr !== it.exp_pc) begin
                    errors++;
                    $display("FAIL %s fetch_addr actual %h expected %h", it.tag, fetch_addr, it.exp_pc);
                end
                if (it.chk_rd) begin
                    checks++;
                    if (reg_rdata !== it.exp_rd) begin
                        errors++;
                        $display("FAIL %s reg_rdata actual %h expected %h", it.tag, reg_rdata, it.exp_rd);
                    end
                end
            end
        end
    end

    // Driver: one cycle of stimulus; queues expectations from the reference model.
    task automatic cyc(input bit inc, input bit add, input logic [7:0] av,
                       input bit wr, input bit rd, input logic [1:0] a,
                       input logic [7:0] wd, input bit chk, input string tag);
        item_t it;
        logic [AW-1:0] n_pc;
        logic [7:0]    n_hi, lo;
        logic [UW-1:0] n_up;
        @(negedge clk);
        inc_en = inc; add_en = add; add_val = av;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        it.exp_pc = m_pc;
        it.chk_rd = chk;
        it.tag    = tag;
        case (a)
            2'd0: it.exp_rd = m_pc[7:0];
            2'd1: it.exp_rd = m_hi;
            2'd2: it.exp_rd = {{(8-UW){1'b0}}, m_up};
            default: it.exp_rd = 8'h00;
        endcase
        q.push_back(it);
        n_pc = m_pc; n_hi = m_hi; n_up = m_up;
        if (add) begin
            lo   = m_pc[7:0] + av;
            n_pc = {m_up, m_hi, lo[7:1], 1'b0};
        end else if (wr && a == 2'd0) begin
            n_pc = {m_up, m_hi, wd[7:1], 1'b0};
        end else if (inc) begin
            n_pc = m_pc + AW'(2);
        end
        if (wr && a == 2'd1) n_hi = wd;
        if (wr && a == 2'd2) n_up = wd[UW-1:0];
        if (!wr && rd && a == 2'd0) begin
            n_hi = m_pc[15:8];
            n_up = m_pc[AW-1:16];
        end
        @(posedge clk);
        m_pc = n_pc; m_hi = n_hi; m_up = n_up;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d, input string tag);
        cyc(0, 0, 8'h00, 1, 0, a, d, 0, tag);
    endtask
    task automatic rd_reg(input logic [1:0] a, input string tag);
        cyc(0, 0, 8'h00, 0, 1, a, 8'h00, 1, tag);
    endtask
    task automatic step(input string tag);
        cyc(1, 0, 8'h00, 0, 0, 2'd0, 8'h00, 0, tag);
    endtask
    task automatic jump(input logic [7:0] v, input string tag);
        cyc(0, 1, v, 0, 0, 2'd0, 8'h00, 0, tag);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_reg(2'd1, "R1 high latch after reset");
        rd_reg(2'd2, "R1 upper latch after reset");
        // R2 stepping by two
        for (int i = 0; i < 4; i++) step("R2 step");
        // R7 latch read/write, unaffected by stepping
        wr_reg(2'd1, 8'h12, "R7 write high");
        wr_reg(2'd2, 8'h03, "R7 write upper");
        step("R7 step keeps latch");
        rd_reg(2'd1, "R7 high readback");
        rd_reg(2'd2, "R7 upper readback");
        // R5 and R3: odd low write lands even, loads upper from latches
        wr_reg(2'd0, 8'h45, "R5 R3 odd low write");
        rd_reg(2'd1, "R5 latch untouched by write");
        // R5 write wins over increment
        cyc(1, 0, 8'h00, 1, 0, 2'd0, 8'h80, 0, "R5 write beats step");
        // R2 carry and wrap at ADDR_W
        wr_reg(2'd1, 8'hFF, "R2 setup high");
        wr_reg(2'd2, 8'hFF, "R7 upper truncation");
        rd_reg(2'd2, "R7 upper reads zero above width");
        wr_reg(2'd0, 8'hFE, "R2 load top");
        step("R2 wrap");
        step("R2 after wrap");
        wr_reg(2'd1, 8'h00, "R2 setup high");
        wr_reg(2'd2, 8'h00, "R2 setup upper");
        wr_reg(2'd0, 8'hFC, "R2 setup low");
        step("R2 carry into high");
        step("R2 carry into high");
        // Lookup table: stale latches, read low refreshes, offset lands on the entry
        wr_reg(2'd1, 8'h01, "R6 table high");
        wr_reg(2'd0, 8'h40, "R6 table base");      // address 0x000140
        wr_reg(2'd1, 8'h77, "R6 stale high");
        wr_reg(2'd2, 8'h09, "R6 stale upper");
        step("R6 step"); step("R6 step"); step("R6 step"); // address 0x000146
        rd_reg(2'd0, "R4 low read");
        rd_reg(2'd1, "R4 refreshed high");
        rd_reg(2'd2, "R4 refreshed upper");
        jump(8'h06, "R6 table jump");               // lands on 0x00014C
        rd_reg(2'd0, "R6 table entry low");
        // R3 odd offset
        jump(8'h05, "R3 odd offset");
        // R6 no carry out of low byte
        jump(8'hFC, "R6 no carry");
        // R6 jump takes upper bits from latches, not live address
        wr_reg(2'd0, 8'hF8, "R6 setup");
        for (int i = 0; i < 6; i++) step("R6 cross boundary");
        jump(8'h10, "R6 jump from latches");
        rd_reg(2'd1, "R6 latch not refreshed");
        cyc(1, 1, 8'h02, 1, 0, 2'd0, 8'h40, 0, "R6 add beats write and step");
        // R8 select 3
        rd_reg(2'd3, "R8 reads zero");
        wr_reg(2'd3, 8'hAA, "R8 write ignored");
        rd_reg(2'd1, "R8 high unchanged");
        rd_reg(2'd2, "R8 upper unchanged");
        cyc(0, 0, 8'h00, 0, 0, 2'd0, 8'h00, 1, "R8 final state");
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule